// File: doc/BRIEF.md
# Serial Line Register Front End

This block sits between a host register bus and a small 8-bit UART core. It presents one asynchronous serial line to software as four 16-bit word registers: receive status, receive buffer, transmit status and transmit buffer. A program can poll the two flags, or it can set the per-direction enables and take interrupts. The block keeps the receive-done and transmit-ready flags. It captures framing, parity and overrun errors for every character. It drives the break control to the core and raises separate receive and transmit interrupt requests. Each request has its own vector.

The UART core delivers a received character as a one-cycle valid pulse, together with its framing and parity status. It accepts a transmit character on a strobe, which is issued only while the core reports that it can take one. Each direction holds exactly one character. A receive character that is not read before the next one completes is lost, and that loss is reported as overrun. The register window is eight bytes long, starts at the `BASE_ADDR` parameter, and must be aligned to eight bytes. The transmit vector is `VEC_BASE` plus 4.

Top module: `sline_unit`

## Requirements
- R1: Only the eight-byte window at `BASE_ADDR` responds, decoded on address bits [2:1]: 0 receive status, 1 receive buffer, 2 transmit status, 3 transmit buffer. The transmit buffer, every unused bit and every access outside the window read as 0, and writes outside the window change nothing.
- R2: Receive status bit 6 is a read/write interrupt enable. Bit 7 is the receiver done flag, which is read-only, so a write to it is ignored.
- R3: Receiver done rises in the cycle after the core's valid pulse. It clears after a read of the receive buffer or after a bus initialize.
- R4: The receive buffer reads the character in bits 7:0, parity error in bit 12, framing error in bit 13, overrun in bit 14, and in bit 15 the OR of bits 14:12.
- R5: A character that completes while receiver done is set, with no buffer read in the same cycle, replaces the held character and sets overrun. The next character that completes with done clear has overrun 0.
- R6: The framing status from the core is stored with every character. The parity status is stored only while `par_chk_en` is 1 and otherwise reads 0.
- R7: Transmit status bit 7 is the read-only transmitter ready flag, bit 6 is the read/write transmit interrupt enable, and bit 0 is the read/write break enable. `txc_break` equals bit 0.
- R8: Ready is 1 after reset. A transmit buffer write clears it and holds the low byte. While `txc_ready` is 1, the block shows that byte on `txc_data` with `txc_strobe` high for one cycle, and ready returns in the cycle after that.
- R9: When a flag and its enable become set together, a request rises one cycle later. It stays high until it is acknowledged or until the flag or the enable clears. A new 0-to-1 step of the enable while the flag is set raises a fresh request.
- R10: `irq_vec` shows `VEC_BASE` for a receive request and `VEC_BASE`+4 for a transmit request, with receive first when both are pending, and 0 when neither is pending. `irq_ack` drops only the request that is shown.
- R11: A bus initialize clears both enables, break, receiver done, the error bits, a pending transmit character and both requests, and sets ready.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_init | input | 1 | Synchronous bus initialize |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (a buffer read has a side effect) |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational |
| par_chk_en | input | 1 | Parity checking configured |
| rxc_valid | input | 1 | Core: character complete |
| rxc_data | input | 8 | Core: received character |
| rxc_frm_err | input | 1 | Core: bad stop bit |
| rxc_par_err | input | 1 | Core: parity mismatch |
| txc_ready | input | 1 | Core: can take a character |
| txc_strobe | output | 1 | Hand-off of a transmit character |
| txc_data | output | 8 | Transmit character |
| txc_break | output | 1 | Hold the line at space |
| rx_irq | output | 1 | Receive interrupt request |
| tx_irq | output | 1 | Transmit interrupt request |
| irq_vec | output | VEC_W | Vector of the request being shown |
| irq_ack | input | 1 | Acknowledge of the shown request |

## Verification
The bench builds the block with a 16-bit address whose window base is 0xFF70 and with a 9-bit vector base of 48. With these values the receive vector is 48 and the transmit vector is 52. The address 0xFF78 sits just past the window and differs from the base only in bit 3, so it shows that the window compare covers every upper address bit. The 9-bit vector shows that the add of 4 does not wrap.

// File: rtl/sline_pkg.sv
package sline_pkg;
  localparam int REG_W  = 16;
  localparam int CHAR_W = 8;
  localparam int NCH    = 2;   // channel 0 receive, channel 1 transmit

  typedef enum logic [1:0] {
    RG_RSTAT = 2'd0,
    RG_RBUF  = 2'd1,
    RG_TSTAT = 2'd2,
    RG_TBUF  = 2'd3
  } reg_idx_e;

  function automatic logic err_sum(input logic par, input logic frm, input logic ovr);
    return par | frm | ovr;
  endfunction

  function automatic logic [REG_W-1:0] pack_rstat(input logic done, input logic ie);
    return {8'h00, done, ie, 6'b000000};
  endfunction

  function automatic logic [REG_W-1:0] pack_rbuf(input logic par, input logic frm,
                                                 input logic ovr, input logic [CHAR_W-1:0] d);
    return {err_sum(par, frm, ovr), ovr, frm, par, 4'b0000, d};
  endfunction

  function automatic logic [REG_W-1:0] pack_tstat(input logic rdy, input logic ie, input logic brk);
    return {8'h00, rdy, ie, 5'b00000, brk};
  endfunction

  function automatic int vec_of(input int base, input int ch);
    return base + 4 * ch;
  endfunction
endpackage

// File: rtl/sline_rx.sv
module sline_rx
  import sline_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic              csr_wr,
  input  logic              wr_ie,
  input  logic              buf_rd,
  input  logic              par_chk_en,
  input  logic              core_valid,
  input  logic [CHAR_W-1:0] core_data,
  input  logic              core_frm,
  input  logic              core_par,
  output logic              done,
  output logic              ie,
  output logic [CHAR_W-1:0] data,
  output logic              par,
  output logic              frm,
  output logic              ovr
);
  logic late_char;   // character lands on an unread one
  logic take_char;

  assign take_char = core_valid;
  assign late_char = core_valid & done & ~buf_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0; ie <= 1'b0; data <= '0;
      par  <= 1'b0; frm <= 1'b0; ovr <= 1'b0;
    end else if (init) begin
      done <= 1'b0; ie <= 1'b0;
      par  <= 1'b0; frm <= 1'b0; ovr <= 1'b0;
    end else begin
      if (csr_wr) ie <= wr_ie;
      if (take_char) begin
        data <= core_data;
        frm  <= core_frm;
        par  <= core_par & par_chk_en;
        ovr  <= late_char;
        done <= 1'b1;
      end else if (buf_rd) begin
        done <= 1'b0;
      end
    end
  end

  AST_DONE_CLR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n || init)
    (buf_rd && !core_valid) |=> !done);  // R3
  AST_OVR_ON_LATE: assert property (@(posedge clk) disable iff (!rst_n || init)
    (core_valid && done && !buf_rd) |=> ovr);  // R5
  AST_PAR_MASKED: assert property (@(posedge clk) disable iff (!rst_n || init)
    (core_valid && !par_chk_en) |=> !par);  // R6
endmodule

// File: rtl/sline_tx.sv
module sline_tx
  import sline_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic              csr_wr,
  input  logic              wr_ie,
  input  logic              wr_brk,
  input  logic              buf_wr,
  input  logic [CHAR_W-1:0] buf_wdata,
  input  logic              core_ready,
  output logic              rdy,
  output logic              ie,
  output logic              brk,
  output logic              core_strobe,
  output logic [CHAR_W-1:0] core_data
);
  logic pend;
  logic handoff;

  assign handoff     = pend & core_ready;
  assign core_strobe = handoff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy <= 1'b1; ie <= 1'b0; brk <= 1'b0; pend <= 1'b0; core_data <= '0;
    end else if (init) begin
      rdy <= 1'b1; ie <= 1'b0; brk <= 1'b0; pend <= 1'b0;
    end else begin
      if (csr_wr) begin
        ie  <= wr_ie;
        brk <= wr_brk;
      end
      if (buf_wr) begin
        core_data <= buf_wdata;
        pend      <= 1'b1;
        rdy       <= 1'b0;
      end else if (handoff) begin
        pend <= 1'b0;
        rdy  <= 1'b1;
      end
    end
  end

  AST_WR_CLEARS_RDY: assert property (@(posedge clk) disable iff (!rst_n || init)
    buf_wr |=> !rdy);  // R8
  AST_RDY_AFTER_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n || init)
    (core_strobe && !buf_wr) |=> rdy);  // R8
endmodule

// File: rtl/sline_irq.sv
module sline_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic init,
  input  logic flag,
  input  logic en,
  input  logic ack,
  output logic req,
  output logic rise_evt
);
  logic cond, cond_q;

  assign cond     = flag & en;
  assign rise_evt = cond & ~cond_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_q <= 1'b0; req <= 1'b0;
    end else if (init) begin
      cond_q <= 1'b0; req <= 1'b0;
    end else begin
      cond_q <= cond;
      req    <= cond & (rise_evt | (req & ~ack));
    end
  end

  AST_RISE_RAISES: assert property (@(posedge clk) disable iff (!rst_n || init)
    rise_evt |=> req);  // R9
  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n || init)
    (ack && !rise_evt) |=> !req);  // R10
endmodule

// File: rtl/sline_unit.sv
module sline_unit
  import sline_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hFF70,
  parameter int                VEC_W     = 9,
  parameter int                VEC_BASE  = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_init,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              par_chk_en,
  input  logic              rxc_valid,
  input  logic [CHAR_W-1:0] rxc_data,
  input  logic              rxc_frm_err,
  input  logic              rxc_par_err,
  input  logic              txc_ready,
  output logic              txc_strobe,
  output logic [CHAR_W-1:0] txc_data,
  output logic              txc_break,
  output logic              rx_irq,
  output logic              tx_irq,
  output logic [VEC_W-1:0]  irq_vec,
  input  logic              irq_ack
);
  localparam int WIN_LSB = 3;
  localparam logic [VEC_W-1:0] VEC_RX = VEC_W'(vec_of(VEC_BASE, 0));
  localparam logic [VEC_W-1:0] VEC_TX = VEC_W'(vec_of(VEC_BASE, 1));

  logic     win_hit;
  reg_idx_e idx;
  logic     wr_rstat, rd_rbuf, wr_tstat, wr_tbuf;

  assign win_hit  = bus_sel && (bus_addr[ADDR_W-1:WIN_LSB] == BASE_ADDR[ADDR_W-1:WIN_LSB]);
  assign idx      = reg_idx_e'(bus_addr[2:1]);
  assign wr_rstat = win_hit & bus_wr & (idx == RG_RSTAT);
  assign rd_rbuf  = win_hit & bus_rd & (idx == RG_RBUF);
  assign wr_tstat = win_hit & bus_wr & (idx == RG_TSTAT);
  assign wr_tbuf  = win_hit & bus_wr & (idx == RG_TBUF);

  logic              rx_done, rx_ie, rx_par, rx_frm, rx_ovr;
  logic [CHAR_W-1:0] rx_data;
  logic              tx_rdy, tx_ie, tx_brk;

  sline_rx u_rx (
    .clk(clk), .rst_n(rst_n), .init(bus_init),
    .csr_wr(wr_rstat), .wr_ie(bus_wdata[6]), .buf_rd(rd_rbuf),
    .par_chk_en(par_chk_en), .core_valid(rxc_valid), .core_data(rxc_data),
    .core_frm(rxc_frm_err), .core_par(rxc_par_err),
    .done(rx_done), .ie(rx_ie), .data(rx_data),
    .par(rx_par), .frm(rx_frm), .ovr(rx_ovr)
  );

  sline_tx u_tx (
    .clk(clk), .rst_n(rst_n), .init(bus_init),
    .csr_wr(wr_tstat), .wr_ie(bus_wdata[6]), .wr_brk(bus_wdata[0]),
    .buf_wr(wr_tbuf), .buf_wdata(bus_wdata[CHAR_W-1:0]),
    .core_ready(txc_ready), .rdy(tx_rdy), .ie(tx_ie), .brk(tx_brk),
    .core_strobe(txc_strobe), .core_data(txc_data)
  );

  assign txc_break = tx_brk;

  always_comb begin
    bus_rdata = '0;
    if (win_hit && bus_rd) begin
      unique case (idx)
        RG_RSTAT: bus_rdata = pack_rstat(rx_done, rx_ie);
        RG_RBUF:  bus_rdata = pack_rbuf(rx_par, rx_frm, rx_ovr, rx_data);
        RG_TSTAT: bus_rdata = pack_tstat(tx_rdy, tx_ie, tx_brk);
        default:  bus_rdata = '0;
      endcase
    end
  end

  // interrupt channels: 0 = receive (higher priority), 1 = transmit
  logic [NCH-1:0] ch_flag, ch_en, ch_ack, ch_req, ch_rise;
  assign ch_flag = {tx_rdy, rx_done};
  assign ch_en   = {tx_ie, rx_ie};
  assign ch_ack  = {irq_ack & ~ch_req[0] & ch_req[1], irq_ack & ch_req[0]};

  for (genvar c = 0; c < NCH; c++) begin : g_irq
    sline_irq u_irq (
      .clk(clk), .rst_n(rst_n), .init(bus_init),
      .flag(ch_flag[c]), .en(ch_en[c]), .ack(ch_ack[c]),
      .req(ch_req[c]), .rise_evt(ch_rise[c])
    );
  end

  assign rx_irq  = ch_req[0];
  assign tx_irq  = ch_req[1];
  assign irq_vec = ch_req[0] ? VEC_RX : (ch_req[1] ? VEC_TX : '0);

  AST_INIT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_init |=> (tx_rdy && !rx_done && !rx_irq && !tx_irq && !txc_break));  // R11
endmodule

// File: tb/tb_sline_unit.sv
module tb_sline_unit;
  localparam logic [15:0] BASE = 16'hFF70;
  localparam logic [8:0]  VRX  = 9'd48;
  localparam logic [8:0]  VTX  = 9'd52;

  logic clk = 0, rst_n = 0, bus_init = 0, bus_sel = 0, bus_wr = 0, bus_rd = 0;
  logic [15:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
  logic par_chk_en = 0, rxc_valid = 0, rxc_frm_err = 0, rxc_par_err = 0, txc_ready = 0;
  logic [7:0] rxc_data = '0, txc_data;
  logic txc_strobe, txc_break, rx_irq, tx_irq, irq_ack = 0;
  logic [8:0] irq_vec;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  sline_unit #(.ADDR_W(16), .BASE_ADDR(BASE), .VEC_W(9), .VEC_BASE(48)) dut (
    .clk(clk), .rst_n(rst_n), .bus_init(bus_init), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .par_chk_en(par_chk_en), .rxc_valid(rxc_valid), .rxc_data(rxc_data),
    .rxc_frm_err(rxc_frm_err), .rxc_par_err(rxc_par_err), .txc_ready(txc_ready),
    .txc_strobe(txc_strobe), .txc_data(txc_data), .txc_break(txc_break),
    .rx_irq(rx_irq), .tx_irq(tx_irq), .irq_vec(irq_vec), .irq_ack(irq_ack)
  );

  // {chk, par, frm, data, expected buffer word}
  localparam logic [26:0] RXV [6] = '{
    {1'b0, 1'b0, 1'b0, 8'h41, 16'h0041},
    {1'b0, 1'b0, 1'b1, 8'h00, 16'hA000},
    {1'b1, 1'b1, 1'b0, 8'h7E, 16'h907E},
    {1'b0, 1'b1, 1'b0, 8'h55, 16'h0055},
    {1'b1, 1'b1, 1'b1, 8'hFF, 16'hB0FF},
    {1'b1, 1'b0, 1'b0, 8'h80, 16'h0080}
  };

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [15:0] d);
    @(negedge clk); bus_sel = 1; bus_rd = 1; bus_addr = a;
    #2 d = bus_rdata;
    @(negedge clk); bus_sel = 0; bus_rd = 0;
  endtask

  task automatic rx_char(input logic [7:0] d, input logic f, input logic p);
    @(negedge clk); rxc_valid = 1; rxc_data = d; rxc_frm_err = f; rxc_par_err = p;
    @(negedge clk); rxc_valid = 0; rxc_frm_err = 0; rxc_par_err = 0;
  endtask

  task automatic ack_pulse();
    @(negedge clk); irq_ack = 1;
    @(negedge clk); irq_ack = 0;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // reset state
    rd(BASE + 0, v); chk("R2 reset rstat", v, 16'h0000);
    rd(BASE + 4, v); chk("R8 reset tstat", v, 16'h0080);
    chk("R9 reset irqs", {14'b0, rx_irq, tx_irq}, 16'h0);

    // table of received characters
    for (int i = 0; i < 6; i++) begin
      par_chk_en = RXV[i][26];
      rx_char(RXV[i][23:16], RXV[i][24], RXV[i][25]);
      rd(BASE + 0, v); chk("R3 done set", v, 16'h0080);
      rd(BASE + 2, v); chk("R4 R6 buffer word", v, RXV[i][15:0]);
      rd(BASE + 0, v); chk("R3 done cleared by read", v, 16'h0000);
    end
    par_chk_en = 0;

    // overrun
    rx_char(8'h31, 0, 0);
    rx_char(8'h32, 0, 0);
    rd(BASE + 2, v); chk("R5 overrun", v, 16'hC032);
    rx_char(8'h33, 0, 0);
    rd(BASE + 2, v); chk("R5 overrun clears", v, 16'h0033);

    // read-only done, enable r/w
    wr(BASE + 0, 16'hFFFF);
    rd(BASE + 0, v); chk("R2 done read-only", v, 16'h0040);
    wr(BASE + 0, 16'h0000);

    // decode
    rd(BASE + 6, v); chk("R1 tbuf reads zero", v, 16'h0000);
    wr(BASE + 8, 16'h0041);
    rd(BASE + 4, v); chk("R1 outside write ignored", v, 16'h0080);
    rd(BASE + 8, v); chk("R1 outside read zero", v, 16'h0000);

    // transmit status and break
    wr(BASE + 4, 16'hFFFF);
    rd(BASE + 4, v); chk("R7 tstat bits", v, 16'h00C1);
    chk("R7 break out", {15'b0, txc_break}, 16'h1);
    wr(BASE + 4, 16'h0000);
    rd(BASE + 4, v); chk("R7 tstat cleared", v, 16'h0080);
    chk("R7 break off", {15'b0, txc_break}, 16'h0);

    // transmit handoff
    wr(BASE + 6, 16'h01A5);
    rd(BASE + 4, v); chk("R8 ready cleared", v, 16'h0000);
    chk("R8 no strobe while core busy", {15'b0, txc_strobe}, 16'h0);
    @(negedge clk); txc_ready = 1;
    #2 chk("R8 strobe", {15'b0, txc_strobe}, 16'h1);
    chk("R8 data", {8'h0, txc_data}, 16'h00A5);
    @(negedge clk); txc_ready = 0;
    chk("R8 strobe one cycle", {15'b0, txc_strobe}, 16'h0);
    rd(BASE + 4, v); chk("R8 ready back", v, 16'h0080);

    // transmit interrupt
    wr(BASE + 4, 16'h0040);
    chk("R9 request one cycle later", {15'b0, tx_irq}, 16'h0);
    @(negedge clk);
    chk("R9 tx request", {15'b0, tx_irq}, 16'h1);
    chk("R10 tx vector", {7'b0, irq_vec}, {7'b0, VTX});
    wr(BASE + 4, 16'h0000);
    @(negedge clk);
    chk("R9 enable clear drops", {15'b0, tx_irq}, 16'h0);
    wr(BASE + 4, 16'h0040);
    @(negedge clk);
    chk("R9 fresh request", {15'b0, tx_irq}, 16'h1);
    ack_pulse();
    @(negedge clk);
    chk("R9 ack holds off", {15'b0, tx_irq}, 16'h0);

    // priority
    wr(BASE + 4, 16'h0000);
    wr(BASE + 4, 16'h0040);
    wr(BASE + 0, 16'h0040);
    rx_char(8'h5A, 0, 0);
    @(negedge clk);
    chk("R10 both pending", {14'b0, rx_irq, tx_irq}, 16'h3);
    chk("R10 rx first", {7'b0, irq_vec}, {7'b0, VRX});
    ack_pulse();
    chk("R10 ack drops rx", {14'b0, rx_irq, tx_irq}, 16'h1);
    chk("R10 then tx vector", {7'b0, irq_vec}, {7'b0, VTX});
    ack_pulse();
    chk("R10 ack drops tx", {14'b0, rx_irq, tx_irq}, 16'h0);
    chk("R10 idle vector", {7'b0, irq_vec}, 16'h0);
    rd(BASE + 2, v); chk("R4 prio char", v, 16'h005A);

    // initialize
    wr(BASE + 4, 16'h0041);
    rx_char(8'h66, 1, 0);
    @(negedge clk); bus_init = 1;
    @(negedge clk); bus_init = 0;
    rd(BASE + 0, v); chk("R11 rstat", v, 16'h0000);
    rd(BASE + 4, v); chk("R11 tstat", v, 16'h0080);
    rd(BASE + 2, v); chk("R11 errors cleared", v, 16'h0066);
    chk("R11 outputs", {13'b0, txc_break, rx_irq, tx_irq}, 16'h0);

    summary();
    $finish;
  end
endmodule